// File: doc/BRIEF.md
# I2C Master Command Sequencer

The block is a single-master I2C byte engine. Software drives it through an 8-bit command register and a one-byte transmit holding register. Some command bits are plain settings. The send-start and send-stop bits can only be set by software and are cleared by the engine itself. The engine produces START, repeated START and STOP conditions. It moves each held byte into a shift register and clocks it out MSB first, then samples the acknowledge bit. It reports through an interrupt when the holding register is empty.

A down-counter that reloads from `baud_div_i` paces the bus. SCL changes level once per reload, so one SCL period spans two reload intervals. When the engine is disabled and the timer-request bit is set, the same counter runs freely and raises a one-cycle interrupt on every reload.

Arbitration loss is only detected and flagged. Slave operation is not part of the block.

Top module: `i2c_cmd_seq`

## Requirements
- R1: The command register resets to 0x00 and reads back `{enable[7], start[6], stop[5], timer_req[4], txe_irq_en[3], nak_cfg[2], 0[1], filter_en[0]}`. A write loads bits 7, 4, 3, 2 and 0 directly, and bit 1 always reads 0.
- R2: Start (bit 6) and stop (bit 5) are set only by a write that also carries enable=1. A write of 0 to either bit leaves it set, and a write with enable=0 never sets them.
- R3: Writing enable=0 clears start and stop. One cycle later the bus is released (scl_o=1, sda_o=1).
- R4: While start is pending and the holding register is empty, no START condition appears on the bus and start stays set.
- R5: With data held, a pending start produces a START condition, then the byte MSB first on SCL rising edges. The holding register empties when the byte enters the shift register (txe_o=1), and start is already clear by then.
- R6: The 9th bit of each byte is sampled. nak_o is 1 if it was high and 0 if it was pulled low.
- R7: A start set while a byte is shifting produces a repeated START after that byte's acknowledge bit, followed by the next held byte.
- R8: Start and stop set in one write give START, one byte, then STOP. Stop clears once the STOP condition has been sent.
- R9: With enable=0 and timer_req=1, irq_o pulses for one cycle on every counter reload. The pulses fall N-1 cycles after the write and then every N cycles, where N = baud_div_i ≥ 2.
- R10: timer_req has no effect on irq_o while enable=1.
- R11: With enable=1 and txe_irq_en=1, irq_o equals the holding-register-empty status.
- R12: Writing 1 to bit 1 empties the holding register, so txe_o=1.
- R13: If SDA reads low while the engine drives a 1 data bit, the engine releases the bus, clears start and stop, and sets arb_lost_o. A write that sets start clears arb_lost_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Command register write strobe |
| ctl_wdata_i | input | 8 | Command register write data |
| ctl_o | output | 8 | Command register read-back |
| data_wr_i | input | 1 | Holding register write strobe |
| data_wdata_i | input | DATA_W | Byte to transmit |
| baud_div_i | input | DIV_W | Counter reload value |
| scl_o | output | 1 | SCL level (0 pulls low) |
| sda_o | output | 1 | SDA drive level (0 pulls low) |
| sda_i | input | 1 | Sensed SDA bus level |
| txe_o | output | 1 | Holding register empty |
| nak_o | output | 1 | Last acknowledge bit was high |
| arb_lost_o | output | 1 | Arbitration lost flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Command register fields settle one cycle after a write. The bench checks them against its own model at every falling edge, and checks start and stop right after the writes that touch them. Timer pulses fall at fixed offsets N-1, 2N-1 and so on after the write, so irq_o is compared on each of those cycles. Bus activity only moves on counter reloads, so the bench decodes START, bytes, acknowledge and STOP from scl_o and SDA into a queue. It compares that queue only after stop has cleared, which keeps those checks independent of the exact reload timing.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int unsigned CB_EN    = 7;
  localparam int unsigned CB_START = 6;
  localparam int unsigned CB_STOP  = 5;
  localparam int unsigned CB_TMR   = 4;
  localparam int unsigned CB_TXI   = 3;
  localparam int unsigned CB_NAK   = 2;
  localparam int unsigned CB_FLUSH = 1;
  localparam int unsigned CB_FILT  = 0;

  typedef struct packed {
    logic en;
    logic start;
    logic stop;
    logic tmr;
    logic txi;
    logic nak;
    logic filt;
  } ctl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START_A, ST_START_B, ST_BIT_LO, ST_BIT_HI, ST_ACK_LO,
    ST_ACK_HI, ST_HOLD, ST_RS_A, ST_RS_B, ST_STOP_A, ST_STOP_B
  } eng_state_e;
endpackage

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             at_one;

  assign at_one = (cnt_q <= DIV_W'(1));
  assign tick_o = run_i && at_one;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || at_one)  cnt_q <= div_i;
    else                        cnt_q <= cnt_q - DIV_W'(1);
  end
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              load_i,
  input  logic              start_done_i,
  input  logic              stop_done_i,
  input  logic              abort_i,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              arb_lost_o
);
  ctl_t              c_q, c_d;
  logic [DATA_W-1:0] data_q;
  logic              full_q, arb_q;
  logic              set_start, set_stop, flush;

  assign set_start = ctl_wr_i && ctl_wdata_i[CB_EN] && ctl_wdata_i[CB_START];
  assign set_stop  = ctl_wr_i && ctl_wdata_i[CB_EN] && ctl_wdata_i[CB_STOP];
  assign flush     = ctl_wr_i && ctl_wdata_i[CB_FLUSH];

  always_comb begin
    c_d = c_q;
    if (ctl_wr_i) begin
      c_d.en   = ctl_wdata_i[CB_EN];
      c_d.tmr  = ctl_wdata_i[CB_TMR];
      c_d.txi  = ctl_wdata_i[CB_TXI];
      c_d.nak  = ctl_wdata_i[CB_NAK];
      c_d.filt = ctl_wdata_i[CB_FILT];
    end
    if (start_done_i || abort_i) c_d.start = 1'b0;
    if (stop_done_i || abort_i)  c_d.stop  = 1'b0;
    // software set wins over a same-cycle hardware clear
    if (set_start) c_d.start = 1'b1;
    if (set_stop)  c_d.stop  = 1'b1;
    if (!c_d.en) begin
      c_d.start = 1'b0;
      c_d.stop  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q    <= '0;
      data_q <= '0;
      full_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      c_q <= c_d;
      if (data_wr_i) begin
        data_q <= data_wdata_i;
        full_q <= 1'b1;
      end else if (load_i || flush) begin
        full_q <= 1'b0;
      end
      if (abort_i)        arb_q <= 1'b1;
      else if (set_start) arb_q <= 1'b0;
    end
  end

  assign ctl_o      = c_q;
  assign data_o     = data_q;
  assign full_o     = full_q;
  assign arb_lost_o = arb_q;

  assert_start_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q.en && c_q.start && !start_done_i && !abort_i && !(ctl_wr_i && !ctl_wdata_i[CB_EN]))
    |=> c_q.start);
  assert_disable_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !ctl_wdata_i[CB_EN]) |=> (!c_q.start && !c_q.stop));
  assert_load_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !data_wr_i) |=> !full_q);
  assert_abort_flags_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !ctl_wr_i) |=> (arb_q && !c_q.start && !c_q.stop));
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sda_i,
  input  logic              filt_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              load_o,
  output logic              start_done_o,
  output logic              stop_done_o,
  output logic              abort_o,
  output logic              nak_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  eng_state_e        st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              nak_q, nak_d;
  logic              s1_q, s2_q, sf_q, sda_in;

  // glitch filter: accept a level once two samples agree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      sf_q <= 1'b1;
    end else begin
      s1_q <= sda_i;
      s2_q <= s1_q;
      if (s1_q == s2_q) sf_q <= s2_q;
    end
  end
  assign sda_in = filt_i ? sf_q : sda_i;

  always_comb begin
    st_d         = st_q;
    sh_d         = sh_q;
    cnt_d        = cnt_q;
    nak_d        = nak_q;
    load_o       = 1'b0;
    start_done_o = 1'b0;
    stop_done_o  = 1'b0;
    abort_o      = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i && full_i)  st_d = ST_START_A;
          else if (stop_i && !start_i) stop_done_o = 1'b1;
        end
        ST_START_A: begin
          st_d         = ST_START_B;
          start_done_o = 1'b1;
        end
        ST_BIT_LO: st_d = ST_BIT_HI;
        ST_BIT_HI: begin
          if (sh_q[DATA_W-1] && !sda_in) begin
            abort_o = 1'b1;
            st_d    = ST_IDLE;
          end else if (cnt_q == LAST_BIT) begin
            st_d = ST_ACK_LO;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
            sh_d  = {sh_q[DATA_W-2:0], 1'b0};
            st_d  = ST_BIT_LO;
          end
        end
        ST_ACK_LO: st_d = ST_ACK_HI;
        ST_RS_A:   st_d = ST_RS_B;
        ST_RS_B:   st_d = ST_START_A;
        ST_STOP_A: st_d = ST_STOP_B;
        ST_STOP_B: begin
          st_d        = ST_IDLE;
          stop_done_o = 1'b1;
        end
        default: begin
          // START_B, ACK_HI, HOLD: choose what follows a byte boundary
          if (st_q == ST_ACK_HI) nak_d = sda_in;
          if (st_q != ST_START_B && start_i) begin
            st_d = ST_RS_A;
          end else if (st_q != ST_START_B && stop_i) begin
            st_d = ST_STOP_A;
          end else if (full_i) begin
            load_o = 1'b1;
            sh_d   = data_i;
            cnt_d  = '0;
            st_d   = ST_BIT_LO;
          end else if (stop_i) begin
            st_d = ST_STOP_A;
          end else begin
            st_d = ST_HOLD;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      nak_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      nak_q <= nak_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE:              begin scl_o = 1'b1; sda_o = 1'b1; end
      ST_START_A:           begin scl_o = 1'b1; sda_o = 1'b0; end
      ST_BIT_LO:            begin scl_o = 1'b0; sda_o = sh_q[DATA_W-1]; end
      ST_BIT_HI:            begin scl_o = 1'b1; sda_o = sh_q[DATA_W-1]; end
      ST_ACK_LO:            begin scl_o = 1'b0; sda_o = 1'b1; end
      ST_ACK_HI:            begin scl_o = 1'b1; sda_o = 1'b1; end
      ST_RS_A:              begin scl_o = 1'b0; sda_o = 1'b1; end
      ST_RS_B:              begin scl_o = 1'b1; sda_o = 1'b1; end
      ST_STOP_B:            begin scl_o = 1'b1; sda_o = 1'b0; end
      default:              begin scl_o = 1'b0; sda_o = 1'b0; end
    endcase
  end

  assign nak_o = nak_q;

  assert_wait_for_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !full_i) |=> (st_q == ST_IDLE));
  assert_release_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && sda_o));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [7:0]        ctl_o,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  output logic              scl_o,
  output logic              sda_o,
  input  logic              sda_i,
  output logic              txe_o,
  output logic              nak_o,
  output logic              arb_lost_o,
  output logic              irq_o
);
  ctl_t              ctl;
  logic [DATA_W-1:0] hold_data;
  logic              full, tick, load, start_done, stop_done, abort;

  i2c_ctl_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .data_wr_i    (data_wr_i),
    .data_wdata_i (data_wdata_i),
    .load_i       (load),
    .start_done_i (start_done),
    .stop_done_i  (stop_done),
    .abort_i      (abort),
    .ctl_o        (ctl),
    .data_o       (hold_data),
    .full_o       (full),
    .arb_lost_o   (arb_lost_o)
  );

  i2c_baud_gen #(.DIV_W(DIV_W)) i_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctl.en || ctl.tmr),
    .div_i  (baud_div_i),
    .tick_o (tick)
  );

  i2c_bit_engine #(.DATA_W(DATA_W)) i_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctl.en),
    .tick_i       (tick),
    .start_i      (ctl.start),
    .stop_i       (ctl.stop),
    .full_i       (full),
    .data_i       (hold_data),
    .sda_i        (sda_i),
    .filt_i       (ctl.filt),
    .scl_o        (scl_o),
    .sda_o        (sda_o),
    .load_o       (load),
    .start_done_o (start_done),
    .stop_done_o  (stop_done),
    .abort_o      (abort),
    .nak_o        (nak_o)
  );

  assign ctl_o = {ctl.en, ctl.start, ctl.stop, ctl.tmr, ctl.txi, ctl.nak, 1'b0, ctl.filt};
  assign txe_o = !full;
  assign irq_o = (ctl.en && ctl.txi && !full) || (!ctl.en && ctl.tmr && tick);

  assert_txe_after_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> !txe_o);
endmodule

// File: tb/test_i2c_cmd_seq.sv
module test_i2c_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wd = '0;
  logic [7:0] ctl_rd;
  logic       data_wr = 1'b0;
  logic [7:0] data_wd = '0;
  logic [15:0] div = 16'd5;
  logic       scl, sda_drv, sda_bus, txe, nak, arb, irq;
  logic       drv_low = 1'b0;
  logic       arb_force = 1'b0;
  logic       ack_en = 1'b1;

  int n_vec = 0;
  int n_bad = 0;
  int evq[$];
  int bitn = 0;
  logic [8:0] sh = '0;
  logic scl_p = 1'b1;
  logic sda_p = 1'b1;
  logic [7:0] model = '0;

  always #5 clk = ~clk;

  assign sda_bus = sda_drv & ~drv_low & ~arb_force;

  i2c_cmd_seq i_i2c_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .ctl_o(ctl_rd),
    .data_wr_i(data_wr), .data_wdata_i(data_wd), .baud_div_i(div), .scl_o(scl),
    .sda_o(sda_drv), .sda_i(sda_bus), .txe_o(txe), .nak_o(nak), .arb_lost_o(arb),
    .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle model compare of the plain command fields and bus decoder
  always @(negedge clk) begin
    if (rst_n) begin
      check((ctl_rd & 8'h9F) == (model & 8'h9F), "R1", int'(ctl_rd & 8'h9F), int'(model & 8'h9F));
      if (scl && scl_p && sda_p && !sda_bus) begin
        evq.push_back(1000);
        bitn = 0;
      end else if (scl && scl_p && !sda_p && sda_bus) begin
        evq.push_back(2000);
      end else if (scl && !scl_p) begin
        sh = {sh[7:0], sda_bus};
        bitn++;
        if (bitn == 9) evq.push_back(int'(sh[8:1]) + (sh[0] ? 512 : 0));
      end else if (!scl && scl_p) begin
        if (bitn == 8) drv_low = ack_en;
        else if (bitn >= 9) begin
          drv_low = 1'b0;
          bitn = 0;
        end
      end
      scl_p = scl;
      sda_p = sda_bus;
    end
  end

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1;
    ctl_wd = v;
    @(posedge clk);
    model = v & 8'h9D;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    data_wr = 1'b1;
    data_wd = v;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit probe(input int sel);
    case (sel)
      0: return txe;
      1: return !ctl_rd[6];
      2: return !ctl_rd[5];
      3: return arb;
      default: return evq.size() != 0;
    endcase
  endfunction

  task automatic wait_for(input int sel, input string req);
    int n = 0;
    while (!probe(sel) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(n < 4000, req, n, 0);
  endtask

  task automatic cmp_events(input int exp[$], input string req);
    check(evq.size() == exp.size(), req, evq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < evq.size(); i++)
      check(evq[i] == exp[i], req, evq[i], exp[i]);
    evq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    check(ctl_rd == 8'h00, "R1", ctl_rd, 0);
    check(scl && sda_drv, "R3", {scl, sda_drv}, 3);
    check(txe && !irq && !arb, "R12", {txe, irq, arb}, 4);
    rst_n = 1'b1;
    idle(1);

    // R9 timer pulses every 5 cycles, first at k=4
    wr_ctl(8'h10);
    for (int k = 0; k < 16; k++) begin
      check(irq == ((k % 5) == 4), "R9", irq, (k % 5) == 4);
      @(negedge clk);
    end
    wr_ctl(8'h70);
    check(ctl_rd[6:5] == 2'b00, "R2", ctl_rd[6:5], 0);

    // R10 timer request ignored while enabled
    wr_ctl(8'h90);
    for (int k = 0; k < 12; k++) begin
      check(!irq, "R10", irq, 0);
      @(negedge clk);
    end

    // R11 / R12
    wr_ctl(8'h98);
    check(irq, "R11", irq, 1);
    wr_data(8'h77);
    check(!txe && !irq, "R11", {txe, irq}, 0);
    wr_ctl(8'h9A);
    check(txe && irq, "R12", {txe, irq}, 3);
    wr_ctl(8'h80);

    // R4 start waits for data, R2 write of 0 does not clear
    wr_ctl(8'hC0);
    idle(60);
    check(evq.size() == 0, "R4", evq.size(), 0);
    check(ctl_rd[6], "R4", ctl_rd[6], 1);
    wr_ctl(8'h80);
    check(ctl_rd[6], "R2", ctl_rd[6], 1);

    // R5 basic byte with stop
    wr_data(8'hA5);
    wait_for(0, "R5");
    check(!ctl_rd[6], "R5", ctl_rd[6], 0);
    wr_ctl(8'hA8);
    check(irq, "R11", irq, 1);
    wait_for(2, "R8");
    idle(10);
    cmp_events('{1000, 8'hA5, 2000}, "R5");
    check(!nak, "R6", nak, 0);
    check(scl && sda_drv, "R5", {scl, sda_drv}, 3);
    wr_ctl(8'h80);

    // R7 repeated start mid-byte; second byte not acknowledged
    wr_ctl(8'hC0);
    wr_data(8'h3C);
    wait_for(0, "R7");
    wr_data(8'h81);
    idle(20);
    wr_ctl(8'hC0);
    check(ctl_rd[6], "R7", ctl_rd[6], 1);
    wait_for(0, "R7");
    check(!ctl_rd[6], "R7", ctl_rd[6], 0);
    ack_en = 1'b0;
    wr_ctl(8'hA0);
    wait_for(2, "R7");
    idle(10);
    cmp_events('{1000, 8'h3C, 1000, 8'h81 + 512, 2000}, "R7");
    check(nak, "R6", nak, 1);
    ack_en = 1'b1;

    // R8 start and stop together
    wr_data(8'h5A);
    idle(15);
    wr_ctl(8'hE0);
    wait_for(2, "R8");
    check(!ctl_rd[6], "R8", ctl_rd[6], 0);
    idle(10);
    cmp_events('{1000, 8'h5A, 2000}, "R8");

    // R3 disable mid-transfer
    wr_data(8'h11);
    wr_ctl(8'hC0);
    idle(40);
    wr_ctl(8'h00);
    check(ctl_rd[6:5] == 2'b00, "R3", ctl_rd[6:5], 0);
    idle(1);
    check(scl && sda_drv, "R3", {scl, sda_drv}, 3);
    wr_ctl(8'h02);
    wr_ctl(8'h60);
    check(ctl_rd[6:5] == 2'b00, "R2", ctl_rd[6:5], 0);
    idle(5);
    evq.delete();

    // R13 arbitration loss
    wr_ctl(8'h80);
    wr_data(8'h80);
    wr_ctl(8'hC0);
    wait_for(4, "R13");
    arb_force = 1'b1;
    wait_for(3, "R13");
    check(ctl_rd[6:5] == 2'b00, "R13", ctl_rd[6:5], 0);
    idle(1);
    check(scl && sda_drv, "R13", {scl, sda_drv}, 3);
    arb_force = 1'b0;
    wr_ctl(8'hC0);
    check(!arb, "R13", arb, 0);
    wr_ctl(8'h00);
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule